// File: doc/BRIEF.md
# Watchdog Power-Cycle Sequencer

This block is a slow secondary watchdog that runs beside a faster primary one. Software must keep changing the level of the `kick` input. Every change, rising or falling, restarts the timeout count. If the count reaches the selected timeout, the block does more than reset the processor. It pulls the active-low reset output low, turns off every regulator enable, and keeps them all off for a power-off interval. It then turns the enables back on one at a time in a fixed index order, with a step delay between each one. Finally it holds reset low for a reset-pulse interval and releases it.

One of several undervoltage reset lines is chosen by `rail_sel`. While the chosen line is high, the reset output is low and the count is held at zero. A strap input and one code of the timeout select each switch the watchdog off completely. During the power-cycle sequence, kicks are ignored. Counting starts again from zero only once reset is released. All inputs are sampled on `clk`. The kick input passes through a synchronizer, so kicks may be asynchronous. The undervoltage lines are expected to be synchronous already.

Top module: `pcyc_watchdog`

## Requirements
- R1: While `rst_n` is low and right after it is released, `rst_out_n` is high and every bit of `reg_en` is high.
- R2: The timeout T is TMO_BASE·2^`tmo_sel` clock cycles for `tmo_sel` 0 to 6. With no kicks, the trip happens on the (T+3)-th rising edge after the last change of `kick`. On that edge `rst_out_n` goes low while all enables stay high.
- R3: A rising change and a falling change of `kick` both restart the count. This holds for a level that lasts only one clock period.
- R4: All bits of `reg_en` go low together, one cycle after `rst_out_n` falls on a trip.
- R5: Every enable stays low for POFF_CYC cycles. During that time `rst_out_n` stays low.
- R6: After the power-off interval, `reg_en[0]` rises first. Each higher index follows STEP_CYC cycles after the one below it. Only one bit changes per step, and no enable falls again.
- R7: `rst_out_n` rises STEP_CYC+RP_CYC cycles after the highest enable rises, and only while all enables are high.
- R8: Changes of `kick` during the sequence have no effect. After the release, the next trip (with no kicks) comes on the T-th rising edge after the release edge.
- R9: While `uv_rail[rail_sel]` is high, `rst_out_n` is low, with no clock delay, and the count is held at zero. After it falls, the trip comes on the T-th rising edge.
- R10: With `wd_off` high or `tmo_sel` = 7, no trip occurs. When the watchdog is switched back on, the count starts from zero, so the trip comes on the T-th edge.
- R11: Undervoltage lines other than `uv_rail[rail_sel]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| kick | input | 1 | Watchdog service input; any level change restarts the count |
| uv_rail | input | N_RAIL | Undervoltage reset request, one line per candidate rail |
| rail_sel | input | clog2(N_RAIL) | Selects the monitored undervoltage line |
| tmo_sel | input | 3 | Timeout code 0..6; 7 switches the watchdog off |
| wd_off | input | 1 | Strap that switches the watchdog off |
| rst_out_n | output | 1 | Active-low system reset |
| reg_en | output | N_REG | Regulator enables, index 0 restored first |

## Verification
The bench measures the exact cycle of every output change against the timing stated in the requirements. A design that missed falling kick edges would trip early after a one-cycle pulse. A design that acted on kicks during the sequence would shift the second trip. A design that counted on from a stale value after release or after an undervoltage event would trip early. Wrong enable order, step spacing or off time shows up as a mismatched value or cycle. The disable code, the strap and an unselected undervoltage line are all held long past the timeout. Any output change during those waits counts as a failure.

// File: rtl/pcyc_pkg.sv
// Package: shared types for the watchdog power-cycle sequencer.
// Assumes: nothing beyond the standard language.
package pcyc_pkg;
    // Phases of the power-cycle sequence; RUN is normal watchdog operation.
    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_TRIP = 3'd1,
        ST_OFF  = 3'd2,
        ST_UP   = 3'd3,
        ST_HOLD = 3'd4
    } seq_state_t;
endpackage

// File: rtl/pcyc_edge.sv
// Kick edge detector: synchronizes the kick input and flags every level
// change, rising or falling, as a one-cycle pulse.
// Assumes: kick levels last at least one clock period.
module pcyc_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic kick_edge
);
    logic [SYNC_STAGES:0] shreg;

    // Shift the kick level through the synchronizer and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[SYNC_STAGES-1:0], kick};
    end

    assign kick_edge = shreg[SYNC_STAGES] ^ shreg[SYNC_STAGES-1];
endmodule

// File: rtl/pcyc_timer.sv
// Timeout counter: counts clock cycles while not held, restarts on a kick
// edge, and flags expiry in the cycle the count reaches limit-1.
// Assumes: limit >= 2; hold covers disable, undervoltage and sequence.
module pcyc_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             kick_edge,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    assign expire = !hold && !kick_edge && (cnt >= limit - 1'b1);

    // Advance, clear or hold the timeout count.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (hold || kick_edge || expire) cnt <= '0;
        else                                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pcyc_seq.sv
// Power-cycle sequencer: on expire, asserts reset, drops all enables for
// POFF_CYC cycles, restores them one per STEP_CYC in index order, then
// holds reset for RP_CYC cycles before returning to RUN.
// Assumes: all interval parameters are at least 1; N_REG >= 2.
module pcyc_seq
    import pcyc_pkg::*;
#(
    parameter int N_REG    = 3,
    parameter int POFF_CYC = 12,
    parameter int STEP_CYC = 4,
    parameter int RP_CYC   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire,
    output logic             running,
    output logic             seq_rst_n,
    output logic [N_REG-1:0] en
);
    localparam int MAX_A = (POFF_CYC > STEP_CYC) ? POFF_CYC : STEP_CYC;
    localparam int MAX_C = (MAX_A > RP_CYC) ? MAX_A : RP_CYC;
    localparam int TW    = $clog2(MAX_C + 1);
    localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1;

    seq_state_t       state;
    logic [TW-1:0]    tmr;
    logic [IDX_W-1:0] idx;

    // Walk through the sequence phases and their interval timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            tmr   <= '0;
            idx   <= '0;
        end else begin
            case (state)
                ST_RUN: begin
                    tmr <= '0;
                    idx <= '0;
                    if (expire) state <= ST_TRIP;
                end
                ST_TRIP: begin
                    tmr   <= '0;
                    state <= ST_OFF;
                end
                ST_OFF: begin
                    if (tmr == TW'(POFF_CYC - 1)) begin
                        tmr   <= '0;
                        idx   <= '0;
                        state <= ST_UP;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_UP: begin
                    if (tmr == TW'(STEP_CYC - 1)) begin
                        tmr <= '0;
                        if (idx == IDX_W'(N_REG - 1)) state <= ST_HOLD;
                        else                          idx   <= idx + 1'b1;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (tmr == TW'(RP_CYC - 1)) begin
                        tmr   <= '0;
                        state <= ST_RUN;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assign running   = (state == ST_RUN);
    assign seq_rst_n = (state == ST_RUN);

    // One enable per regulator: on outside the off/ramp phases, and during
    // the ramp once the step index has reached it.
    for (genvar i = 0; i < N_REG; i++) begin : g_en
        assign en[i] = (state == ST_RUN) || (state == ST_TRIP) ||
                       (state == ST_HOLD) ||
                       ((state == ST_UP) && (idx >= IDX_W'(i)));
    end
endmodule

// File: rtl/pcyc_watchdog.sv
// Top: secondary watchdog with power-cycle recovery. Selects the monitored
// undervoltage line, decodes the timeout and disable conditions, and ties
// the kick detector, timeout counter and sequencer together.
// Assumes: uv_rail is synchronous to clk; kick may be asynchronous.
module pcyc_watchdog #(
    parameter int N_REG       = 3,
    parameter int N_RAIL      = 4,
    parameter int TMO_BASE    = 8,
    parameter int POFF_CYC    = 12,
    parameter int STEP_CYC    = 4,
    parameter int RP_CYC      = 6,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(N_RAIL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic [N_RAIL-1:0] uv_rail,
    input  logic [SEL_W-1:0]  rail_sel,
    input  logic [2:0]        tmo_sel,
    input  logic              wd_off,
    output logic              rst_out_n,
    output logic [N_REG-1:0]  reg_en
);
    localparam int CNT_W = $clog2(TMO_BASE) + 8;
    localparam logic [2:0] SEL_OFF = 3'd7;

    logic             kick_edge;
    logic             uv_sel;
    logic             disabled;
    logic             running;
    logic             seq_rst_n;
    logic             expire;
    logic             hold;
    logic [CNT_W-1:0] limit;

    assign uv_sel    = uv_rail[rail_sel];
    assign disabled  = wd_off || (tmo_sel == SEL_OFF);
    assign limit     = CNT_W'(TMO_BASE) << tmo_sel;
    assign hold      = !running || uv_sel || disabled;
    assign rst_out_n = seq_rst_n && !uv_sel;

    pcyc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick      (kick),
        .kick_edge (kick_edge)
    );

    pcyc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .kick_edge (kick_edge),
        .limit     (limit),
        .expire    (expire)
    );

    pcyc_seq #(
        .N_REG    (N_REG),
        .POFF_CYC (POFF_CYC),
        .STEP_CYC (STEP_CYC),
        .RP_CYC   (RP_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .running   (running),
        .seq_rst_n (seq_rst_n),
        .en        (reg_en)
    );
endmodule

// File: rtl/pcyc_watchdog_chk.sv
// Checker: port-level properties of the power-cycle sequence.
// Assumes: bound to pcyc_watchdog; clocked on its clock and reset.
module pcyc_watchdog_chk #(
    parameter int N_REG = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wd_off,
    input logic [2:0]       tmo_sel,
    input logic             rst_out_n,
    input logic [N_REG-1:0] reg_en
);
    // R4
    drop_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_en) != '0 && reg_en == '0) |-> !$past(rst_out_n));

    // R6
    thermometer_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en & N_REG'(reg_en + 1'b1)) == '0);

    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en != '0) |-> ($countones(reg_en ^ $past(reg_en)) <= 1));

    // R5
    off_keeps_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en != {N_REG{1'b1}}) |-> !rst_out_n);

    // R7
    release_full_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> ((&reg_en) && $past(&reg_en)));

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wd_off || tmo_sel == 3'd7) && rst_out_n && (&reg_en)) |=> (&reg_en));
endmodule

bind pcyc_watchdog pcyc_watchdog_chk #(.N_REG(N_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wd_off    (wd_off),
    .tmo_sel   (tmo_sel),
    .rst_out_n (rst_out_n),
    .reg_en    (reg_en)
);

// File: tb/pcyc_watchdog_test.sv
// Scoreboard bench: driver tasks queue expected output changes with their
// cycle; a monitor compares every observed change against the queue head.
module pcyc_watchdog_test;
    localparam int N_REG    = 3;
    localparam int N_RAIL   = 4;
    localparam int TMO_BASE = 8;
    localparam int POFF_CYC = 12;
    localparam int STEP_CYC = 4;
    localparam int RP_CYC   = 6;
    localparam logic [N_REG-1:0] ALL_ON = {N_REG{1'b1}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              kick = 1'b0;
    logic [N_RAIL-1:0] uv_rail = '0;
    logic [1:0]        rail_sel = '0;
    logic [2:0]        tmo_sel = 3'd1;
    logic              wd_off = 1'b0;
    logic              rst_out_n;
    logic [N_REG-1:0]  reg_en;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    int last_kick = 0;
    bit mon_on = 0;
    bit done = 0;

    int              q_cyc[$];
    logic [N_REG:0]  q_val[$];
    string           q_tag[$];

    pcyc_watchdog #(
        .N_REG(N_REG), .N_RAIL(N_RAIL), .TMO_BASE(TMO_BASE),
        .POFF_CYC(POFF_CYC), .STEP_CYC(STEP_CYC), .RP_CYC(RP_CYC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .kick(kick), .uv_rail(uv_rail),
        .rail_sel(rail_sel), .tmo_sel(tmo_sel), .wd_off(wd_off),
        .rst_out_n(rst_out_n), .reg_en(reg_en)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%s expected=%s (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) tick(1);
    endtask

    task automatic push(input int c, input logic r, input logic [N_REG-1:0] e, input string tag);
        q_cyc.push_back(c);
        q_val.push_back({r, e});
        q_tag.push_back(tag);
    endtask

    // Queue the full power-cycle sequence that starts at trip edge s;
    // returns the release edge.
    task automatic push_cycle(input int s, input string tag, output int rel);
        push(s, 1'b0, ALL_ON, tag);                                   // R2
        push(s + 1, 1'b0, '0, "R4");                                  // R4
        for (int i = 0; i < N_REG; i++)                               // R5 R6
            push(s + 1 + POFF_CYC + i * STEP_CYC, 1'b0,
                 N_REG'((1 << (i + 1)) - 1), "R6");
        rel = s + 1 + POFF_CYC + N_REG * STEP_CYC + RP_CYC;
        push(rel, 1'b1, ALL_ON, "R7");                                // R7
    endtask

    task automatic kick_run(input int n, input int period);
        for (int i = 0; i < n; i++) begin
            if (i % period == 0) begin
                kick = ~kick;
                last_kick = cyc;
            end
            tick(1);
        end
    endtask

    function automatic int tmo(input int sel);
        return TMO_BASE << sel;
    endfunction

    // Monitor: compare every output change with the queue head.
    initial begin
        logic [N_REG:0] prev;
        logic [N_REG:0] now;
        prev = {1'b1, ALL_ON};
        forever begin
            @(negedge clk);
            now = {rst_out_n, reg_en};
            if (mon_on && now !== prev) begin
                if (q_cyc.size() == 0) begin
                    check(1'b0, "unexpected change", $sformatf("%b@%0d", now, cyc), "none");
                end else begin
                    int ec;
                    logic [N_REG:0] ev;
                    string et;
                    ec = q_cyc.pop_front();
                    ev = q_val.pop_front();
                    et = q_tag.pop_front();
                    check(ec == cyc && ev === now, et,
                          $sformatf("%b@%0d", now, cyc), $sformatf("%b@%0d", ev, ec));
                end
                prev = now;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Driver.
    initial begin
        int s;
        int rel;
        int c;
        tick(4);
        // R1: reset state
        check(rst_out_n === 1'b1, "R1", $sformatf("%b", rst_out_n), "1");
        check(reg_en === ALL_ON, "R1", $sformatf("%b", reg_en), $sformatf("%b", ALL_ON));
        rst_n = 1'b1;
        mon_on = 1;
        tick(1);
        check(rst_out_n === 1'b1 && reg_en === ALL_ON, "R1",
              $sformatf("%b%b", rst_out_n, reg_en), "1111");

        // R3: alternating edges keep it alive; then expiry (R2)
        kick_run(60, 4);
        push_cycle(last_kick + tmo(1) + 3, "R2", rel);
        s = last_kick + tmo(1) + 3;
        // R8: kicks during the sequence are ignored
        wait_until(s + 5);
        kick = ~kick;
        wait_until(s + 9);
        kick = ~kick;
        push_cycle(rel + tmo(1), "R8", c);
        wait_until(c);
        kick_run(40, 4);

        // R3: one-cycle pulse, both edges must restart the count
        kick = ~kick;
        tick(1);
        kick = ~kick;
        last_kick = cyc;
        push_cycle(last_kick + tmo(1) + 3, "R3", rel);
        wait_until(rel);
        kick_run(20, 4);

        // R10: strap off, no kicks
        wd_off = 1'b1;
        tick(200);
        check(rst_out_n === 1'b1 && reg_en === ALL_ON, "R10",
              $sformatf("%b%b", rst_out_n, reg_en), "1111");
        wd_off = 1'b0;
        kick_run(20, 4);
        // R10: disable code, then re-enable with sel 0
        tmo_sel = 3'd7;
        tick(200);
        check(rst_out_n === 1'b1 && reg_en === ALL_ON, "R10",
              $sformatf("%b%b", rst_out_n, reg_en), "1111");
        tmo_sel = 3'd0;
        push_cycle(cyc + tmo(0), "R10", rel);
        wait_until(rel);
        kick_run(20, 4);

        // R11: unselected undervoltage line has no effect
        rail_sel = 2'd2;
        uv_rail[1] = 1'b1;
        kick_run(40, 4);
        uv_rail[1] = 1'b0;
        kick_run(8, 4);
        // R9: selected line asserts reset and holds the count
        uv_rail[2] = 1'b1;
        push(cyc + 1, 1'b0, ALL_ON, "R9");
        tick(40);
        uv_rail[2] = 1'b0;
        push(cyc + 1, 1'b1, ALL_ON, "R9");
        push_cycle(cyc + tmo(0), "R9", rel);
        wait_until(rel);

        // R2: longer timeout code
        tmo_sel = 3'd2;
        kick_run(30, 6);
        push_cycle(last_kick + tmo(2) + 3, "R2", rel);
        wait_until(rel);
        kick_run(10, 6);
        tick(5);
        check(q_cyc.size() == 0, "queue drained",
              $sformatf("%0d", q_cyc.size()), "0");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule